// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block makes the 16x oversampling tick that paces a UART's transmitter and receiver, both from the same source. It runs from one free-running input clock and uses no derived clock. The tick is a one-cycle enable in that clock's domain. The input clock first passes through a prescaler that divides by 1 or by `PRE_RATIO`, which is 4 by default. A programmable divider then divides the prescaled rate. For a wanted baud rate, the divisor is `f_in / (prescale * 16 * baud)`.

The divisor is 16 bits wide and is written as separate byte registers through a small write port. A mode register holds the prescaler select bit. A divisor of zero stops tick generation completely and drops the `active` output. Every divisor write restarts the count from zero, and so does any write that changes the prescaler select. The first tick after a restart therefore lands exactly one full period later, with no shortened period in between.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is zero, `active` is low, `tick` is low and the prescaler divides by 1.
- R2: A write to address 0 sets the divisor's low byte and a write to address 1 sets its high byte. A write to address 2 sets the mode register, of which only bit 7 is stored. A write to address 3 has no effect.
- R3: With mode bit 7 at 0 and a divisor D between 1 and 65535, `tick` pulses once every D clock cycles. With D = 1 it is high on every cycle.
- R4: With mode bit 7 at 1, `tick` pulses once every 4*D clock cycles.
- R5: While the divisor is zero, `tick` never rises and `active` is low. While the divisor is nonzero, `active` is high.
- R6: A write to either divisor byte restarts the generator. If that write is sampled at clock edge k, the first tick is high in the cycle that follows edge k + P*D - 1, where P is the prescale factor.
- R7: A mode write that changes bit 7 restarts both the prescaler and the divider. The first tick then comes a full P*D cycles after the write edge, using the new P.
- R8: A mode write that leaves bit 7 unchanged, or that changes only other bits, does not disturb a period that is already running.
- R9: `tick` is never high on two consecutive cycles unless P*D = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 low byte, 1 high byte, 2 mode |
| wr_data | input | BYTE_W | Write data |
| tick | output | 1 | One-cycle tick at 16x the baud rate |
| active | output | 1 | High while the divisor is nonzero |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor, byte-wide registers and a divide-by-4 prescaler. With these settings it sweeps every divisor from 1 to 24 under both prescaler settings and measures three consecutive periods for each, so the divide-by-1 edge case and the restart timing are covered throughout. It also times a divisor set through the high byte alone and the full 65535 divisor. It writes to the mode register in the middle of a running period to separate restarting writes from writes that must have no effect.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    PRE_DIV1 = 1'b0,
    PRE_DIVN = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int RATIO = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pre_mode_e mode_i,
  input  logic      restart_i,
  output logic      en_o
);
  localparam int W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [W-1:0] LAST = W'(RATIO - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i || mode_i == PRE_DIV1) cnt_d = '0;
    else if (cnt_q == LAST)              cnt_d = '0;
    else                                 cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign en_o = (mode_i == PRE_DIV1) || (cnt_q == LAST);

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && mode_i == PRE_DIVN) |=> (!en_o || mode_i == PRE_DIV1)); // R4
endmodule

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int PRE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_o,
  output pre_mode_e         mode_o,
  output logic              restart_o
);
  localparam int NUM_BYTES = DIV_W / BYTE_W;
  localparam int MODE_ADDR = NUM_BYTES;

  logic [NUM_BYTES-1:0] byte_hit;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q, byte_d;
    assign byte_hit[b] = wr_en && (wr_addr == ADDR_W'(b));

    always_comb begin
      byte_d = byte_q;
      if (byte_hit[b]) byte_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign div_o[b*BYTE_W +: BYTE_W] = byte_q;

    AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_hit[b] |=> (div_o[b*BYTE_W +: BYTE_W] == $past(wr_data))); // R2
  end

  pre_mode_e mode_q, mode_d, mode_new;
  logic      mode_wr, mode_chg;

  assign mode_wr  = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
  assign mode_new = pre_mode_e'(wr_data[PRE_BIT]);
  assign mode_chg = mode_wr && (mode_new != mode_q);

  always_comb begin
    mode_d = mode_q;
    if (mode_chg) mode_d = mode_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PRE_DIV1;
    else        mode_q <= mode_d;
  end

  assign mode_o    = mode_q;
  assign restart_o = (|byte_hit) || mode_chg;

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_o)); // R8
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             run, at_end;

  assign run    = |div_i;
  assign at_end = (cnt_q == div_i - DIV_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)             cnt_d = '0;
    else if (en_i && run) begin
      if (at_end) cnt_d = '0;
      else        cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i && run && at_end;

  AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div_i)); // R3
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (div_i < DIV_W'(2) || !tick_o)); // R6
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int PRE_RATIO = 4,
  parameter int PRE_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick,
  output logic              active
);
  logic       rst_s1_q, rst_s2_q;
  logic       srst_n;
  logic [DIV_W-1:0] div;
  pre_mode_e  mode;
  logic       restart, pre_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign srst_n = rst_s2_q;

  baud_cfg_regs #(
    .DIV_W(DIV_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .PRE_BIT(PRE_BIT)
  ) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_o(div), .mode_o(mode), .restart_o(restart)
  );

  baud_prescaler #(.RATIO(PRE_RATIO)) u_pre (
    .clk(clk), .rst_n(srst_n), .mode_i(mode), .restart_i(restart), .en_o(pre_en)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(srst_n), .en_i(pre_en), .load_i(restart),
    .div_i(div), .tick_o(tick)
  );

  assign active = |div;

  logic fast;
  assign fast = (mode == PRE_DIV1) && (div == DIV_W'(1));

  AST_TICK_NEEDS_DIV: assert property (@(posedge clk) disable iff (!srst_n)
    tick |-> active); // R5
  AST_TICK_WIDTH: assert property (@(posedge clk) disable iff (!srst_n)
    (tick && !fast) |=> (!tick || fast)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    !srst_n |-> (!tick && !active)); // R1
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       tick, active;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .active(active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // Counts negedge samples until tick is seen; returns the sample index.
  task automatic wait_tick(input int lim, output int n);
    n = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      n++;
      if (tick) return;
    end
    n = -1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, p, seen;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: idle after reset
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    chk(seen == 0 && !active, "R1", seen, 0);

    // R3/R4/R6: sweep divisors under both prescalers, three periods each
    for (int m = 0; m < 2; m++) begin
      p = (m == 0) ? 1 : 4;
      wr(2'd2, (m == 0) ? 8'h00 : 8'h80);
      wr(2'd1, 8'h00);
      for (int d = 1; d <= 24; d++) begin
        wr(2'd0, 8'(d));
        wait_tick(400, n);
        chk(n == p * d, "R6", n, p * d);
        for (int k = 0; k < 2; k++) begin
          wait_tick(400, n);
          chk(n == p * d, (m == 0) ? "R3" : "R4", n, p * d);
        end
      end
    end

    // R9 / R3: divisor 1 at divide-by-1 ticks every cycle
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    chk(seen == 10, "R3", seen, 10);

    // R9: divisor 2 never gives back-to-back ticks
    wr(2'd0, 8'h02);
    begin
      int prev = 0, dbl = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (tick && prev != 0) dbl++;
        prev = int'(tick);
      end
      chk(dbl == 0, "R9", dbl, 0);
    end

    // R2: high byte alone gives 256, with prescale 4
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    chk(active, "R2", int'(active), 1);
    wait_tick(2000, n);
    chk(n == 1024, "R2", n, 1024);

    // R5: zero divisor stops ticks
    wr(2'd1, 8'h00);
    chk(!active, "R5", int'(active), 0);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    chk(seen == 0, "R5", seen, 0);

    // R8: mode write with unchanged bit 7 (other bits set) mid-period
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h06);
    chk(active, "R5", int'(active), 1);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (n == 2) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h7F; end
      else wr_en = 1'b0;
      if (tick) break;
    end
    wr_en = 1'b0;
    chk(n == 6, "R8", n, 6);

    // R2: address 3 write has no effect mid-period
    wr(2'd0, 8'h05);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (n == 2) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'hFF; end
      else wr_en = 1'b0;
      if (tick) break;
    end
    wr_en = 1'b0;
    chk(n == 5, "R2", n, 5);
    wait_tick(100, n);
    chk(n == 5, "R2", n, 5);

    // R7: switching to divide-by-4 mid-period restarts
    wr(2'd0, 8'h03);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (n == 2) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h80; end
      else wr_en = 1'b0;
      if (tick) break;
    end
    wr_en = 1'b0;
    chk(n == 14, "R7", n, 14);

    // R8: rewriting bit 7 = 1 while already divide-by-4 keeps the period
    wr(2'd0, 8'h03);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (n == 5) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h80; end
      else wr_en = 1'b0;
      if (tick) break;
    end
    wr_en = 1'b0;
    chk(n == 12, "R8", n, 12);

    // R7: switching back to divide-by-1 restarts
    wr(2'd2, 8'h00);
    wait_tick(100, n);
    chk(n == 3, "R7", n, 3);

    // R3: full-scale divisor
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hFF);
    wait_tick(70000, n);
    chk(n == 65535, "R3", n, 65535);

    finish_run();
  end
endmodule